// File: doc/BRIEF.md
# NaN Width Converter

This block translates a not-a-number operand between the 32-bit and the 64-bit binary floating-point encodings. Each operand is first unpacked into a neutral intermediate form. That form holds the sign and a 64-bit payload, with the fraction bits packed against the payload's most significant end. The output format is then packed from that form. A payload that keeps its bits through the change of width passes along unchanged. A payload whose surviving bits are all zero is replaced by the standard NaN of the output format.

The caller supplies a valid strobe, a direction bit and the operand. One clock later the block returns the converted word, a valid strobe and a pulse that marks a signaling operand. A parameter selects the meaning of the fraction's top bit. Either a set top bit means quiet, or a set top bit means signaling. That choice also fixes both standard NaN patterns. Operands that are not NaNs still get the same bit transformation, but no conversion rules beyond it are defined for them.

Top module: `nan_format_converter`

## Requirements
- R1: With `in_dir`=0 (32 to 64 bits), the operand is `in_data[31:0]`. If its fraction bits [22:0] are nonzero, `out_data` is the sign from bit 31, then 11 exponent ones, then those 23 fraction bits in [51:29], and zeros in [28:0].
- R2: With `in_dir`=1 (64 to 32 bits), if `in_data[51:29]` is nonzero, `out_data[31:0]` is the sign from bit 63, then 8 exponent ones, then `in_data[51:29]`. `out_data[63:32]` is zero.
- R3: When the fraction bits that survive the conversion are all zero, the result is the standard NaN of the output format. With QUIET_IS_SET=1 these are 0xFFF8000000000000 (64-bit) and 0xFFC00000 (32-bit). With QUIET_IS_SET=0 they are 0x7FF7FFFFFFFFFFFF and 0x7FBFFFFF.
- R4: `out_invalid` is high with a result exactly when the operand was a signaling NaN. A signaling NaN has an all-ones exponent. With QUIET_IS_SET=1 it also has a clear top fraction bit and other fraction bits that are nonzero. With QUIET_IS_SET=0 it has a set top fraction bit. The top fraction bit is bit 22 for 32-bit operands and bit 51 for 64-bit operands.
- R5: `out_valid` is high in exactly the cycle after `in_valid` was sampled high. `out_invalid` is a single-result pulse that is never high without `out_valid`.
- R6: A cycle with `in_valid` low leaves `out_data` unchanged.
- R7: With `in_dir`=0, `in_data[63:32]` has no effect on any output.
- R8: Synchronous active-high `rst` clears `out_valid`, `out_invalid` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_dir | input | 1 | 0: 32-bit to 64-bit, 1: 64-bit to 32-bit |
| in_data | input | 64 | Operand; the 32-bit operand uses bits [31:0] |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Converted NaN; the 32-bit result uses bits [31:0] |
| out_invalid | output | 1 | Operand was a signaling NaN |

## Verification
The bench builds two instances side by side and drives them with identical stimulus. One uses QUIET_IS_SET=1 and the other QUIET_IS_SET=0. With both polarities present, every operand is classified both ways. Both sets of standard NaN patterns are reached in a single run. An operand that is signaling under one rule and quiet under the other shows whether the flag follows the parameter. Random operands are weighted toward all-ones exponents and toward fractions that vanish on narrowing, so the standard-NaN substitution occurs often in both directions.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

    localparam int CANON_W = 64;

    typedef struct packed {
        logic               sign;
        logic [CANON_W-1:0] payload;
    } canon_t;

    typedef enum logic {
        DIR_WIDEN  = 1'b0,
        DIR_NARROW = 1'b1
    } dir_e;

endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
    import nanconv_pkg::*;
#(
    parameter int EXP_W        = 8,
    parameter int FRAC_W       = 23,
    parameter bit QUIET_IS_SET = 1'b1,
    localparam int WORD_W      = 1 + EXP_W + FRAC_W,
    localparam int PAD_W       = CANON_W - FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output canon_t            canon,
    output logic              is_snan
);

    logic              sign_bit;
    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;
    logic              exp_full;
    logic              top_frac;
    logic              rest_nonzero;

    assign sign_bit   = word[WORD_W-1];
    assign exp_field  = word[WORD_W-2 -: EXP_W];
    assign frac_field = word[FRAC_W-1:0];
    assign exp_full   = &exp_field;
    assign top_frac   = frac_field[FRAC_W-1];
    assign rest_nonzero = |frac_field[FRAC_W-2:0];

    always_comb begin
        canon.sign    = sign_bit;
        canon.payload = {frac_field, {PAD_W{1'b0}}};
    end

    generate
        if (QUIET_IS_SET) begin : g_quiet_set
            assign is_snan = exp_full && !top_frac && rest_nonzero;
        end else begin : g_quiet_clear
            assign is_snan = exp_full && top_frac;
        end
    endgenerate

endmodule

// File: rtl/nan_pack.sv
module nan_pack
    import nanconv_pkg::*;
#(
    parameter int EXP_W        = 8,
    parameter int FRAC_W       = 23,
    parameter bit QUIET_IS_SET = 1'b1,
    localparam int WORD_W      = 1 + EXP_W + FRAC_W,
    localparam int DROP_W      = CANON_W - FRAC_W
) (
    input  canon_t            canon,
    output logic [WORD_W-1:0] word
);

    logic [FRAC_W-1:0] frac_kept;
    logic [DROP_W-1:0] unused_dropped;
    logic [WORD_W-1:0] std_nan;

    assign frac_kept      = canon.payload[CANON_W-1 -: FRAC_W];
    assign unused_dropped = canon.payload[DROP_W-1:0];

    generate
        if (QUIET_IS_SET) begin : g_std_quiet_set
            assign std_nan = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        end else begin : g_std_quiet_clear
            assign std_nan = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
        end
    endgenerate

    always_comb begin
        if (|frac_kept) begin
            word = {canon.sign, {EXP_W{1'b1}}, frac_kept};
        end else begin
            word = std_nan;
        end
    end

endmodule

// File: rtl/nan_format_converter.sv
module nan_format_converter
    import nanconv_pkg::*;
#(
    parameter int NARROW_EXP   = 8,
    parameter int NARROW_FRAC  = 23,
    parameter int WIDE_EXP     = 11,
    parameter int WIDE_FRAC    = 52,
    parameter bit QUIET_IS_SET = 1'b1,
    localparam int NARROW_W    = 1 + NARROW_EXP + NARROW_FRAC,
    localparam int WIDE_W      = 1 + WIDE_EXP + WIDE_FRAC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dir,
    input  logic [WIDE_W-1:0] in_data,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_data,
    output logic              out_invalid
);

    typedef struct packed {
        logic              vld;
        logic              inv;
        logic [WIDE_W-1:0] data;
    } res_t;

    res_t r_d, r_q;

    canon_t              narrow_canon;
    canon_t              wide_canon;
    logic                narrow_snan;
    logic                wide_snan;
    logic [WIDE_W-1:0]   widened;
    logic [NARROW_W-1:0] narrowed;

    nan_unpack #(
        .EXP_W        (NARROW_EXP),
        .FRAC_W       (NARROW_FRAC),
        .QUIET_IS_SET (QUIET_IS_SET)
    ) u_unpack_narrow (
        .word    (in_data[NARROW_W-1:0]),
        .canon   (narrow_canon),
        .is_snan (narrow_snan)
    );

    nan_unpack #(
        .EXP_W        (WIDE_EXP),
        .FRAC_W       (WIDE_FRAC),
        .QUIET_IS_SET (QUIET_IS_SET)
    ) u_unpack_wide (
        .word    (in_data),
        .canon   (wide_canon),
        .is_snan (wide_snan)
    );

    nan_pack #(
        .EXP_W        (WIDE_EXP),
        .FRAC_W       (WIDE_FRAC),
        .QUIET_IS_SET (QUIET_IS_SET)
    ) u_pack_wide (
        .canon (narrow_canon),
        .word  (widened)
    );

    nan_pack #(
        .EXP_W        (NARROW_EXP),
        .FRAC_W       (NARROW_FRAC),
        .QUIET_IS_SET (QUIET_IS_SET)
    ) u_pack_narrow (
        .canon (wide_canon),
        .word  (narrowed)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_valid;
        r_d.inv = 1'b0;
        if (in_valid) begin
            if (in_dir == DIR_NARROW) begin
                r_d.data = {{(WIDE_W-NARROW_W){1'b0}}, narrowed};
                r_d.inv  = wide_snan;
            end else begin
                r_d.data = widened;
                r_d.inv  = narrow_snan;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid   = r_q.vld;
    assign out_invalid = r_q.inv;
    assign out_data    = r_q.data;

endmodule

// File: rtl/nanconv_chk.sv
module nanconv_chk #(
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 64,
    parameter int WIDE_EXP = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_dir,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_data,
    input logic              out_invalid
);

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5
    flag_needs_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> out_valid);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dir) |=> (out_data[WIDE_W-1:NARROW_W] == '0));

    // R1
    wide_exp_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dir) |=> (&out_data[WIDE_W-2 -: WIDE_EXP]));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_invalid && (out_data == '0)));

endmodule

bind nan_format_converter nanconv_chk #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .WIDE_EXP (WIDE_EXP)
) u_nanconv_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dir      (in_dir),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_invalid (out_invalid)
);

// File: tb/tb_nan_format_converter.sv
`timescale 1ns/1ps
module tb_nan_format_converter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dir = 1'b0;
    logic [63:0] in_data = '0;
    logic        ov_a, oi_a, ov_b, oi_b;
    logic [63:0] od_a, od_b;

    int total = 0;
    int bad = 0;
    logic [63:0] last_a = '0;
    logic [63:0] last_b = '0;

    always #2 clk = ~clk;

    nan_format_converter #(.QUIET_IS_SET(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_data(in_data), .out_valid(ov_a), .out_data(od_a), .out_invalid(oi_a)
    );

    nan_format_converter #(.QUIET_IS_SET(1'b0)) dut_alt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_data(in_data), .out_valid(ov_b), .out_data(od_b), .out_invalid(oi_b)
    );

    function automatic logic [63:0] ref_data(logic dir, logic [63:0] d, logic qset);
        logic [22:0] f;
        if (!dir) begin
            f = d[22:0];
            if (f == '0) return qset ? 64'hFFF8000000000000 : 64'h7FF7FFFFFFFFFFFF;
            return {d[31], 11'h7FF, f, 29'b0};
        end
        f = d[51:29];
        if (f == '0) return {32'b0, (qset ? 32'hFFC00000 : 32'h7FBFFFFF)};
        return {32'b0, d[63], 8'hFF, f};
    endfunction

    function automatic logic ref_snan(logic dir, logic [63:0] d, logic qset);
        logic e, q, r;
        if (!dir) begin
            e = (d[30:23] == 8'hFF); q = d[22]; r = (d[21:0] != '0);
        end else begin
            e = (d[62:52] == 11'h7FF); q = d[51]; r = (d[50:0] != '0);
        end
        return qset ? (e && !q && r) : (e && q);
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle, then check both instances after the capturing edge.
    task automatic step(logic v, logic dir, logic [63:0] d, string tag);
        logic [63:0] ea, eb;
        @(negedge clk);
        in_valid = v; in_dir = dir; in_data = d;
        @(posedge clk);
        #1;
        ea = v ? ref_data(dir, d, 1'b1) : last_a;
        eb = v ? ref_data(dir, d, 1'b0) : last_b;
        check({tag, " R5 valid"}, {63'b0, ov_a}, {63'b0, v});
        check({tag, " R5 valid alt"}, {63'b0, ov_b}, {63'b0, v});
        check({tag, " data"}, od_a, ea);
        check({tag, " data alt"}, od_b, eb);
        check({tag, " R4 flag"}, {63'b0, oi_a}, {63'b0, v && ref_snan(dir, d, 1'b1)});
        check({tag, " R4 flag alt"}, {63'b0, oi_b}, {63'b0, v && ref_snan(dir, d, 1'b0)});
        last_a = ea;
        last_b = eb;
    endtask

    function automatic logic [63:0] gen_operand(logic dir);
        logic [63:0] d;
        int kind;
        d = {$urandom, $urandom};
        kind = $urandom % 8;
        if (kind != 0) begin
            if (!dir) d[30:23] = 8'hFF;
            else      d[62:52] = 11'h7FF;
        end
        if (kind == 1) begin
            if (!dir) d[22:0] = 23'($urandom % 2);
            else      d[51:29] = '0;
        end
        if (kind == 2) begin
            if (!dir) d[21:0] = 22'($urandom % 4);
            else      d[50:0] = 51'($urandom % 4);
        end
        return d;
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 reset valid", {62'b0, ov_a, ov_b}, 64'd0);
        check("R8 reset flag", {62'b0, oi_a, oi_b}, 64'd0);
        check("R8 reset data", od_a | od_b, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 quiet narrow payload widened
        step(1'b1, 1'b0, 64'h0000_0000_7FC0_0001, "R1 qnan");
        // R1 R4 signaling narrow operand
        step(1'b1, 1'b0, 64'h0000_0000_FF80_0001, "R1 snan");
        // R3 narrow zero fraction becomes wide standard NaN
        step(1'b1, 1'b0, 64'h0000_0000_7F80_0000, "R3 widen zero");
        // R2 narrowing keeps top fraction bits
        step(1'b1, 1'b1, 64'hFFF8_0000_0000_0000, "R2 qnan");
        step(1'b1, 1'b1, 64'h7FF4_0000_2000_0000, "R2 snan");
        // R3 narrowing drops only low bits set
        step(1'b1, 1'b1, 64'h7FF0_0000_0000_0001, "R3 narrow zero");
        step(1'b1, 1'b1, 64'hFFF8_0000_1FFF_FFFF, "R3 narrow quiet");
        // R6 idle cycles keep data
        step(1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, "R6 idle");
        step(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 idle2");
        // R7 upper bits ignored when widening
        step(1'b1, 1'b0, 64'h0000_0000_7FA0_0005, "R7 clean");
        step(1'b1, 1'b0, 64'hDEAD_BEEF_7FA0_0005, "R7 dirty");
        check("R7 same result", od_a, ref_data(1'b0, 64'h0000_0000_7FA0_0005, 1'b1));

        for (int i = 0; i < 600; i++) begin
            logic dir;
            logic v;
            dir = 1'($urandom % 2);
            v = ($urandom % 5) != 0;
            step(v, dir, gen_operand(dir), "rand");
        end

        // R8 reset mid-stream
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 re-reset valid", {62'b0, ov_a, ov_b}, 64'd0);
        check("R8 re-reset data", od_a | od_b, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule